// File: doc/BRIEF.md
# Wake and Power-Event Flag Register

This block is a small status register that records why a low-power microcontroller subsystem woke and which supply transitions it went through. A push-button line, a PLL-lock signal that stands for "system power good", a pulse from the autowake timer and pulses marking a processor request for sleep or display-only mode drive it. Hardware sets each event flag. Software reads all flags in one register access and clears any flag by writing a zero to its bit.

The push-button and PLL-lock lines are asynchronous. Each passes through a synchronizer chain before its edges are detected, so one edge sets its flag exactly once. A rising lock edge records that power became available. A falling lock edge records a brownout, except when the device is already marked as woken by the button or the timer. When either lock-edge flag is set, the block raises one shared power interrupt request. That request stays high until software has cleared both flags.

The power-mode sequencer, the timers and interrupt priority lie outside this block. The bench drives them as stimulus.

Top module: `pwr_wake_flags`

## Requirements
- R1: After reset every flag reads 0, `pwr_irq_o` is 0, and read bits at positions 4 and above are always 0.
- R2: `rd_data_o` shows all flags at once at fixed bit positions: bit 0 autowake, bit 1 push-button, bit 2 power-available, bit 3 brownout.
- R3: A cycle with `wr_en_i` high clears each flag whose bit in `wr_data_i` is 0. A 1 in a bit leaves that flag unchanged. Write bits at positions 4 and above have no effect.
- R4: The push-button flag is set by a low-to-high transition of `button_i`, seen after synchronization. Holding the line high does not set the flag again once software has cleared it.
- R5: A cycle with `sleep_req_i` or `disp_req_i` high clears the push-button flag.
- R6: The power-available flag is set by a low-to-high transition of `pll_lock_i`.
- R7: The brownout flag is set by a high-to-low transition of `pll_lock_i`. It is not set if the push-button flag or the autowake flag is already set when that transition is detected.
- R8: The autowake flag is set in any cycle where `autowake_i` is high.
- R9: When a hardware set and a clear of the same flag (software write or mode request) fall in the same cycle, the flag ends up set.
- R10: `pwr_irq_o` is high exactly while the power-available flag or the brownout flag is set, so it stays high until both are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all flags |
| button_i | input | 1 | Asynchronous push-button level |
| pll_lock_i | input | 1 | Asynchronous PLL-lock / power-good level |
| autowake_i | input | 1 | Synchronous autowake timer expiry pulse |
| sleep_req_i | input | 1 | Synchronous pulse: processor requests sleep |
| disp_req_i | input | 1 | Synchronous pulse: processor requests display-only mode |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | REG_W | Write data; a 0 bit clears the matching flag |
| rd_data_o | output | REG_W | All flags, zero-extended |
| pwr_irq_o | output | 1 | Shared power interrupt request |

## Verification
The bench holds the button high after clearing its flag. A design that sets the flag on level instead of edge would set it again. It drops the lock line while the button flag or the autowake flag is set, and again while neither is set. A missing suppression would show a false brownout, and a suppression that is too broad would hide a real one. Writes of all ones, and writes that clear only some bits, catch cells that toggle or clear on a 1. An autowake pulse in the same cycle as a clearing write catches a design that lets the clear win. The interrupt is checked after each flag is cleared alone, which exposes an interrupt wired to only one of the two flags.

// File: rtl/pwr_wake_flags_pkg.sv
package pwr_wake_flags_pkg;
   localparam int unsigned NUM_FLAGS = 4;
   localparam int unsigned BIT_AWAKE = 0;
   localparam int unsigned BIT_BTN   = 1;
   localparam int unsigned BIT_PWRUP = 2;
   localparam int unsigned BIT_BROWN = 3;

   typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/pwr_wake_flags_sync.sv
module pwr_wake_flags_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pwr_wake_flags_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_wake_flags_edge.sv
module pwr_wake_flags_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic rise_o,
   output logic fall_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_i;
   end

   assign rise_o = level_i & ~prev_q;
   assign fall_o = ~level_i & prev_q;

   assert_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_o && fall_o));
   assert_rise_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/pwr_wake_flags_cell.sv
module pwr_wake_flags_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_q <= 1'b0;
      else if (set_i)  q_q <= 1'b1;
      else if (clr_i)  q_q <= 1'b0;
   end

   assign q_o = q_q;

   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/pwr_wake_flags.sv
module pwr_wake_flags
   import pwr_wake_flags_pkg::*;
#(
   parameter int unsigned REG_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             button_i,
   input  logic             pll_lock_i,
   input  logic             autowake_i,
   input  logic             sleep_req_i,
   input  logic             disp_req_i,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic [REG_W-1:0] rd_data_o,
   output logic             pwr_irq_o
);
   localparam int unsigned PAD_W = REG_W - NUM_FLAGS;

   if (REG_W < NUM_FLAGS) begin : g_bad_width
      $error("pwr_wake_flags: REG_W must hold all flags");
   end

   logic btn_sync, lock_sync;
   logic btn_rise, btn_fall_unused;
   logic lock_rise, lock_fall;
   flag_vec_t flags, set_vec, clr_vec;

   pwr_wake_flags_sync #(.STAGES(SYNC_STAGES)) u_sync_btn (
      .clk(clk), .rst_n(rst_n), .async_i(button_i), .sync_o(btn_sync));
   pwr_wake_flags_sync #(.STAGES(SYNC_STAGES)) u_sync_lock (
      .clk(clk), .rst_n(rst_n), .async_i(pll_lock_i), .sync_o(lock_sync));

   pwr_wake_flags_edge u_edge_btn (
      .clk(clk), .rst_n(rst_n), .level_i(btn_sync),
      .rise_o(btn_rise), .fall_o(btn_fall_unused));
   pwr_wake_flags_edge u_edge_lock (
      .clk(clk), .rst_n(rst_n), .level_i(lock_sync),
      .rise_o(lock_rise), .fall_o(lock_fall));

   // Hardware set sources; brownout is masked by an already recorded wake
   always_comb begin
      set_vec            = '0;
      set_vec[BIT_AWAKE] = autowake_i;
      set_vec[BIT_BTN]   = btn_rise;
      set_vec[BIT_PWRUP] = lock_rise;
      set_vec[BIT_BROWN] = lock_fall & ~flags[BIT_BTN] & ~flags[BIT_AWAKE];
   end

   // Clear sources: a zero in the write data, plus mode requests for the button
   always_comb begin
      clr_vec = wr_en_i ? ~wr_data_i[NUM_FLAGS-1:0] : '0;
      clr_vec[BIT_BTN] = clr_vec[BIT_BTN] | sleep_req_i | disp_req_i;
   end

   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      pwr_wake_flags_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .set_i(set_vec[f]), .clr_i(clr_vec[f]), .q_o(flags[f]));
   end

   if (PAD_W > 0) begin : g_pad
      assign rd_data_o = {{PAD_W{1'b0}}, flags};
   end else begin : g_nopad
      assign rd_data_o = flags;
   end

   assign pwr_irq_o = flags[BIT_PWRUP] | flags[BIT_BROWN];

   assert_brown_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[BIT_BROWN]) |-> $past(!flags[BIT_BTN] && !flags[BIT_AWAKE] && lock_fall));
   assert_btn_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[BIT_BTN]) |-> $past(btn_rise));
   assert_mode_clears_btn_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((sleep_req_i || disp_req_i) && !btn_rise) |=> !flags[BIT_BTN]);
   assert_irq_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_irq_o && !wr_en_i) |=> pwr_irq_o);
   assert_pwrup_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[BIT_PWRUP]) |-> $past(lock_rise));
   assert_awake_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      autowake_i |=> rd_data_o[BIT_AWAKE]);
endmodule

// File: tb/pwr_wake_flags_tb.sv
module pwr_wake_flags_tb;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic button_i = 1'b0, pll_lock_i = 1'b0, autowake_i = 1'b0;
   logic sleep_req_i = 1'b0, disp_req_i = 1'b0, wr_en_i = 1'b0;
   logic [W-1:0] wr_data_i = '0;
   logic [W-1:0] rd_data_o;
   logic pwr_irq_o;

   int n_checks = 0;
   int n_errors = 0;

   always #2 clk = ~clk;

   pwr_wake_flags #(.REG_W(W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .button_i(button_i), .pll_lock_i(pll_lock_i),
      .autowake_i(autowake_i), .sleep_req_i(sleep_req_i), .disp_req_i(disp_req_i),
      .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
      .pwr_irq_o(pwr_irq_o));

   // {button, lock, autowake, sleep, disp, wr_en, wr_data[3:0], expected[3:0]}
   // expected bit 0 autowake, 1 button, 2 power-available, 3 brownout
   localparam logic [13:0] VEC [22] = '{
      14'b0_1_0_0_0_0_0000_0100, // R6 lock rises
      14'b0_1_0_0_0_1_1011_0000, // R3 clear bit 2 only
      14'b1_1_0_0_0_0_0000_0010, // R4 button rises
      14'b1_1_0_0_0_1_1101_0000, // R3 R4 clear, level held
      14'b0_1_0_0_0_0_0000_0000, // R4 button falls, no set
      14'b0_0_0_0_0_0_0000_1000, // R7 lock falls, unmasked
      14'b0_0_0_0_0_1_0111_0000, // R3 clear brownout
      14'b0_0_1_0_0_0_0000_0001, // R8 autowake pulse
      14'b0_1_0_0_0_0_0000_0101, // R6
      14'b0_0_0_0_0_0_0000_0101, // R7 masked by autowake flag
      14'b0_0_0_0_0_1_1010_0000, // R3 clear bits 0 and 2
      14'b1_0_0_0_0_0_0000_0010, // R4
      14'b1_1_0_0_0_0_0000_0110, // R6
      14'b1_0_0_0_0_0_0000_0110, // R7 masked by button flag
      14'b1_0_0_1_0_0_0000_0100, // R5 sleep clears button
      14'b0_0_0_0_0_0_0000_0100, // R4 fall sets nothing
      14'b1_0_0_0_0_0_0000_0110, // R4
      14'b1_0_0_0_1_0_0000_0100, // R5 display request clears button
      14'b1_0_0_0_0_1_0000_0000, // R3 write zero clears all
      14'b1_1_0_0_0_0_0000_0100, // R6
      14'b1_1_0_0_0_1_1111_0100, // R3 write ones no effect
      14'b1_0_0_0_0_0_0000_1100  // R7 unmasked brownout, R10
   };

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_write(input logic [3:0] d);
      wr_en_i = 1'b1;
      wr_data_i = {{(W-4){1'b1}}, d};
      tick(1);
      wr_en_i = 1'b0;
      wr_data_i = '0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
   end

   initial begin : main
      logic [3:0] e;
      tick(3);
      // R1 reset state
      check("R1 reset flags", rd_data_o, '0);
      check("R1 reset irq", {7'd0, pwr_irq_o}, '0);
      rst_n = 1'b1;
      tick(3);
      check("R1 after release", rd_data_o, '0);

      for (int v = 0; v < 22; v++) begin
         button_i   = VEC[v][13];
         pll_lock_i = VEC[v][12];
         tick(6);
         autowake_i = VEC[v][11];
         tick(1);
         autowake_i = 1'b0;
         sleep_req_i = VEC[v][10];
         disp_req_i  = VEC[v][9];
         tick(1);
         sleep_req_i = 1'b0;
         disp_req_i  = 1'b0;
         if (VEC[v][8]) pulse_write(VEC[v][7:4]);
         tick(1);
         e = VEC[v][3:0];
         check($sformatf("R2 vector %0d flags", v), rd_data_o, {4'd0, e});
         check($sformatf("R10 vector %0d irq", v), {7'd0, pwr_irq_o}, {7'd0, e[3] | e[2]});
      end

      // R10: irq stays while one of the two flags remains
      pulse_write(4'b1011);
      check("R10 brownout alone", {7'd0, pwr_irq_o}, 8'd1);
      pulse_write(4'b0111);
      check("R10 both cleared", {7'd0, pwr_irq_o}, 8'd0);

      // R9: autowake set and clearing write in the same cycle
      autowake_i = 1'b1;
      wr_en_i = 1'b1;
      wr_data_i = '0;
      tick(1);
      autowake_i = 1'b0;
      wr_en_i = 1'b0;
      check("R9 set wins", rd_data_o, 8'h01);
      pulse_write(4'b1110);
      check("R3 clear autowake", rd_data_o, 8'h00);

      // R9: button edge and sleep request in the same cycle (edge lands 3 edges after input)
      button_i = 1'b0;
      tick(6);
      button_i = 1'b1;
      tick(2);
      sleep_req_i = 1'b1;
      tick(1);
      sleep_req_i = 1'b0;
      check("R9 button set beats sleep clear", rd_data_o, 8'h02);

      // R1: reset in mid-run clears flags
      autowake_i = 1'b1;
      tick(1);
      autowake_i = 1'b0;
      rst_n = 1'b0;
      tick(1);
      check("R1 reset clears", rd_data_o, 8'h00);
      rst_n = 1'b1;
      tick(6);
      check("R4 held level after reset sets once", rd_data_o, 8'h02);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule